// File: doc/BRIEF.md
# UART Register Front End

This block is the bus-facing register layer of a UART. It decodes a simple single-cycle read/write port into four 32-bit words: a control word, a receive data window, a transmit data window and a status word. Writing the transmit window issues a one-cycle push to an external TX FIFO, and reading the receive window issues a one-cycle pop from an external RX FIFO. The serial shifters and FIFOs are outside this block. It reaches them only through push/pop strobes, their flag and fill-level inputs, and configuration outputs.

The control word holds the frame format (character length, stop bits, parity mode), the automatic flow-control enable, the run enable, the DMA request enables, the interrupt enables, the loopback switch, and a selector that picks which FIFO fill count appears in the status word. The status word combines five sticky event bits with live FIFO flags, modem line levels and a busy flag. Each sticky bit is cleared by writing a one to it. A level-sensitive, active-high interrupt is raised from the enabled event bits.

Top module: `uart_regbank`

## Requirements
- R1: After reset the control word reads 0x0000_0000 and `irq_o` is low. With both FIFOs empty, all levels zero and the line inputs low, the status word reads 0x0000_0420. Read data appears on `rdata_o` one clock after `rd_en_i` is sampled.
- R2: The control word (byte offset 0x0) keeps these fields: [1:0] character length, [2] two stop bits, [6:4] parity mode, [12] flow control, [14] level select, [15] run enable, [16] RX DMA, [17] TX DMA, [18] RX interrupt enable, [19] TX interrupt enable, [20] loopback. All other bits read back as zero. Each field drives its matching output.
- R3: With loopback set, `rx_line_o` follows `tx_serial_i`. With loopback clear, it follows `rx_serial_i`.
- R4: Clearing run enable drives `tx_run_o` and `rx_run_o` low together. Every other control field keeps its value.
- R5: A write to the TX window (offset 0x8) while `tx_full_i` is low raises `tx_push_o` in that cycle, with `tx_data_o` equal to the low 8 bits of the write data.
- R6: A write to the TX window while `tx_full_i` is high does not push. It sets the TX-error bit, status bit 3.
- R7: Writing the status word (offset 0xC) with a one in bits [4:0] clears the matching sticky bits. Zero bits leave them unchanged.
- R8: A read of the RX window (offset 0x4) while `rx_empty_i` is low pops once and returns the character zero-extended. While `rx_empty_i` is high it returns zero and does not pop.
- R9: Status bits [16:11] show the TX fill level when control bit 14 is set, and the RX fill level when it is clear.
- R10: RX-pending (status bit 0) is set every cycle the RX FIFO is not empty. `irq_o` is high while RX-pending and RX interrupt enable are both set. A clear wins for one cycle, after which the bit re-arms if the condition still holds.
- R11: TX-pending (status bit 1) is set while TX interrupt enable is set and the TX fill level is below half the TX depth. `irq_o` follows it when TX interrupt enable is set.
- R12: The overrun and RX-error input pulses set status bits 2 and 4, which stay set until cleared. These bits do not raise `irq_o`.
- R13: Status bits 5, 6, 7, 8, 10 and 17 mirror RX empty, TX full, CTS, RTS, TX empty and busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| tx_push_o | output | 1 | TX FIFO push |
| tx_data_o | output | DATA_W | TX FIFO push data |
| tx_full_i | input | 1 | TX FIFO full |
| tx_empty_i | input | 1 | TX FIFO empty |
| tx_level_i | input | TX_LVL_W | TX FIFO fill count |
| rx_pop_o | output | 1 | RX FIFO pop |
| rx_data_i | input | DATA_W | RX FIFO head |
| rx_empty_i | input | 1 | RX FIFO empty |
| rx_level_i | input | RX_LVL_W | RX FIFO fill count |
| rx_overrun_i | input | 1 | Overrun event pulse |
| rx_err_i | input | 1 | Receive frame/parity error pulse |
| cts_i | input | 1 | CTS line level |
| rts_i | input | 1 | RTS line level |
| busy_i | input | 1 | Transmitter busy |
| tx_serial_i | input | 1 | Serial output of the TX shifter |
| rx_serial_i | input | 1 | External receive pin |
| rx_line_o | output | 1 | Serial input to the RX shifter |
| word_len_o | output | 2 | Character length code |
| two_stop_o | output | 1 | Two stop bits |
| parity_o | output | 3 | Parity mode code |
| flow_en_o | output | 1 | Automatic flow control |
| tx_run_o | output | 1 | TX shifter run |
| rx_run_o | output | 1 | RX shifter run |
| rx_dma_en_o | output | 1 | RX DMA request enable |
| tx_dma_en_o | output | 1 | TX DMA request enable |
| loopback_o | output | 1 | Loopback active |
| irq_o | output | 1 | Interrupt, active high |

## Verification
The bench uses the default depths of 16 for both FIFOs, which gives 5-bit level inputs and a TX half-depth threshold of 8. Fill levels of 7 and 8 therefore fall on either side of the TX-pending boundary. A full flag and a non-zero level value in each selector position are cheap to drive. Because the FIFOs are modelled as plain bench-driven flags, the bench can create the states that would otherwise need many characters, including an overrun and a write into a full TX FIFO.

// File: rtl/uart_regbank_pkg.sv
package uart_regbank_pkg;
  localparam int unsigned OFF_CTRL = 0;
  localparam int unsigned OFF_RXD  = 4;
  localparam int unsigned OFF_TXD  = 8;
  localparam int unsigned OFF_STAT = 12;

  localparam int unsigned PEND_N   = 5;
  localparam int unsigned P_RX     = 0;
  localparam int unsigned P_TX     = 1;
  localparam int unsigned P_OVR    = 2;
  localparam int unsigned P_TXERR  = 3;
  localparam int unsigned P_RXERR  = 4;

  localparam int unsigned LVL_FIELD_W = 6;

  typedef struct packed {
    logic       loopback;
    logic       tx_ie;
    logic       rx_ie;
    logic       tx_dma;
    logic       rx_dma;
    logic       enable;
    logic       lvl_sel_tx;
    logic       flow_en;
    logic [2:0] parity;
    logic       two_stop;
    logic [1:0] word_len;
  } ctrl_t;

  function automatic logic [31:0] ctrl_to_word(ctrl_t c);
    logic [31:0] w;
    w        = '0;
    w[1:0]   = c.word_len;
    w[2]     = c.two_stop;
    w[6:4]   = c.parity;
    w[12]    = c.flow_en;
    w[14]    = c.lvl_sel_tx;
    w[15]    = c.enable;
    w[16]    = c.rx_dma;
    w[17]    = c.tx_dma;
    w[18]    = c.rx_ie;
    w[19]    = c.tx_ie;
    w[20]    = c.loopback;
    return w;
  endfunction
endpackage

// File: rtl/uart_regbank_ctrl.sv
module uart_regbank_ctrl
  import uart_regbank_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [31:0] wdata_i,
  output ctrl_t       ctrl_o,
  output logic [31:0] rdback_o
);
  ctrl_t ctrl_d;
  logic  unused_wbits;

  always_comb begin
    ctrl_d.word_len   = wdata_i[1:0];
    ctrl_d.two_stop   = wdata_i[2];
    ctrl_d.parity     = wdata_i[6:4];
    ctrl_d.flow_en    = wdata_i[12];
    ctrl_d.lvl_sel_tx = wdata_i[14];
    ctrl_d.enable     = wdata_i[15];
    ctrl_d.rx_dma     = wdata_i[16];
    ctrl_d.tx_dma     = wdata_i[17];
    ctrl_d.rx_ie      = wdata_i[18];
    ctrl_d.tx_ie      = wdata_i[19];
    ctrl_d.loopback   = wdata_i[20];
  end

  assign unused_wbits = ^{wdata_i[31:21], wdata_i[13], wdata_i[11:7], wdata_i[3]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctrl_o <= '0;
    else if (we_i) ctrl_o <= ctrl_d;
  end

  assign rdback_o = ctrl_to_word(ctrl_o);
endmodule

// File: rtl/uart_regbank_pend.sv
module uart_regbank_pend #(
  parameter int unsigned N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] irq_mask_i,
  output logic [N-1:0] pend_o,
  output logic         irq_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    // clear wins; a held condition re-arms next cycle
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        pend_o[i] <= 1'b0;
      else if (clr_i[i])  pend_o[i] <= 1'b0;
      else if (set_i[i])  pend_o[i] <= 1'b1;
    end
  end

  assign irq_o = |(pend_o & irq_mask_i);
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
  import uart_regbank_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned TX_DEPTH = 16,
  parameter int unsigned RX_DEPTH = 16,
  localparam int unsigned TX_LVL_W = $clog2(TX_DEPTH + 1),
  localparam int unsigned RX_LVL_W = $clog2(RX_DEPTH + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic                rd_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o,
  output logic                tx_push_o,
  output logic [DATA_W-1:0]   tx_data_o,
  input  logic                tx_full_i,
  input  logic                tx_empty_i,
  input  logic [TX_LVL_W-1:0] tx_level_i,
  output logic                rx_pop_o,
  input  logic [DATA_W-1:0]   rx_data_i,
  input  logic                rx_empty_i,
  input  logic [RX_LVL_W-1:0] rx_level_i,
  input  logic                rx_overrun_i,
  input  logic                rx_err_i,
  input  logic                cts_i,
  input  logic                rts_i,
  input  logic                busy_i,
  input  logic                tx_serial_i,
  input  logic                rx_serial_i,
  output logic                rx_line_o,
  output logic [1:0]          word_len_o,
  output logic                two_stop_o,
  output logic [2:0]          parity_o,
  output logic                flow_en_o,
  output logic                tx_run_o,
  output logic                rx_run_o,
  output logic                rx_dma_en_o,
  output logic                tx_dma_en_o,
  output logic                loopback_o,
  output logic                irq_o
);
  localparam logic [TX_LVL_W-1:0] TX_HALF = TX_LVL_W'(TX_DEPTH / 2);

  logic sel_ctrl, sel_rxd, sel_txd, sel_stat;
  assign sel_ctrl = (addr_i == ADDR_W'(OFF_CTRL));
  assign sel_rxd  = (addr_i == ADDR_W'(OFF_RXD));
  assign sel_txd  = (addr_i == ADDR_W'(OFF_TXD));
  assign sel_stat = (addr_i == ADDR_W'(OFF_STAT));

  ctrl_t       ctrl;
  logic [31:0] ctrl_word;

  uart_regbank_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (wr_en_i & sel_ctrl),
    .wdata_i  (wdata_i),
    .ctrl_o   (ctrl),
    .rdback_o (ctrl_word)
  );

  logic rx_ie, tx_ie;
  assign rx_ie = ctrl.rx_ie;
  assign tx_ie = ctrl.tx_ie;

  // FIFO strobes
  logic tx_drop;
  assign tx_push_o = wr_en_i & sel_txd & ~tx_full_i;
  assign tx_drop   = wr_en_i & sel_txd &  tx_full_i;
  assign tx_data_o = wdata_i[DATA_W-1:0];
  assign rx_pop_o  = rd_en_i & sel_rxd & ~rx_empty_i;

  // sticky event bits
  logic [PEND_N-1:0] pend_set, pend_clr, pend_mask, pend;
  always_comb begin
    pend_set          = '0;
    pend_set[P_RX]    = ~rx_empty_i;
    pend_set[P_TX]    = tx_ie & (tx_level_i < TX_HALF);
    pend_set[P_OVR]   = rx_overrun_i;
    pend_set[P_TXERR] = tx_drop;
    pend_set[P_RXERR] = rx_err_i;
    pend_clr          = (wr_en_i & sel_stat) ? wdata_i[PEND_N-1:0] : '0;
    pend_mask         = '0;
    pend_mask[P_RX]   = rx_ie;
    pend_mask[P_TX]   = tx_ie;
  end

  uart_regbank_pend #(.N(PEND_N)) u_pend (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (pend_set),
    .clr_i      (pend_clr),
    .irq_mask_i (pend_mask),
    .pend_o     (pend),
    .irq_o      (irq_o)
  );

  logic pend_rx, pend_ovr, pend_txerr;
  assign pend_rx    = pend[P_RX];
  assign pend_ovr   = pend[P_OVR];
  assign pend_txerr = pend[P_TXERR];

  // status word
  logic [LVL_FIELD_W-1:0] lvl_field;
  logic [31:0]            stat_word;
  assign lvl_field = ctrl.lvl_sel_tx ? LVL_FIELD_W'(tx_level_i) : LVL_FIELD_W'(rx_level_i);

  always_comb begin
    stat_word        = '0;
    stat_word[4:0]   = pend;
    stat_word[5]     = rx_empty_i;
    stat_word[6]     = tx_full_i;
    stat_word[7]     = cts_i;
    stat_word[8]     = rts_i;
    stat_word[10]    = tx_empty_i;
    stat_word[16:11] = lvl_field;
    stat_word[17]    = busy_i;
  end

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (sel_ctrl)                 rd_mux = ctrl_word;
    else if (sel_stat)            rd_mux = stat_word;
    else if (sel_rxd && !rx_empty_i) rd_mux = 32'(rx_data_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_mux;
  end

  // configuration outputs
  assign word_len_o  = ctrl.word_len;
  assign two_stop_o  = ctrl.two_stop;
  assign parity_o    = ctrl.parity;
  assign flow_en_o   = ctrl.flow_en;
  assign tx_run_o    = ctrl.enable;
  assign rx_run_o    = ctrl.enable;
  assign rx_dma_en_o = ctrl.rx_dma;
  assign tx_dma_en_o = ctrl.tx_dma;
  assign loopback_o  = ctrl.loopback;
  assign rx_line_o   = ctrl.loopback ? tx_serial_i : rx_serial_i;
endmodule

// File: rtl/uart_regbank_chk.sv
module uart_regbank_chk #(
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wbit0_i,
  input logic              wbit2_i,
  input logic              tx_full_i,
  input logic              tx_push_o,
  input logic              rx_empty_i,
  input logic              rx_pop_o,
  input logic              loopback_o,
  input logic              tx_serial_i,
  input logic              rx_line_o,
  input logic              tx_run_o,
  input logic              rx_run_o,
  input logic              pend_rx_i,
  input logic              pend_ovr_i,
  input logic              pend_txerr_i
);
  logic stat_wr, txd_wr;
  assign stat_wr = wr_en_i && (addr_i == ADDR_W'(12));
  assign txd_wr  = wr_en_i && (addr_i == ADDR_W'(8));

  assert_no_push_full_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_full_i |-> !tx_push_o);

  assert_drop_flags_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txd_wr && tx_full_i) |=> pend_txerr_i);

  assert_no_pop_empty_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_empty_i |-> !rx_pop_o);

  assert_loop_route_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loopback_o |-> (rx_line_o == tx_serial_i));

  assert_run_pair_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_run_o == rx_run_o);

  assert_rx_pend_arm_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_empty_i && !(stat_wr && wbit0_i)) |=> pend_rx_i);

  assert_w1c_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_wr && wbit2_i) |=> !pend_ovr_i);
endmodule

bind uart_regbank uart_regbank_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .addr_i       (addr_i),
  .wbit0_i      (wdata_i[0]),
  .wbit2_i      (wdata_i[2]),
  .tx_full_i    (tx_full_i),
  .tx_push_o    (tx_push_o),
  .rx_empty_i   (rx_empty_i),
  .rx_pop_o     (rx_pop_o),
  .loopback_o   (loopback_o),
  .tx_serial_i  (tx_serial_i),
  .rx_line_o    (rx_line_o),
  .tx_run_o     (tx_run_o),
  .rx_run_o     (rx_run_o),
  .pend_rx_i    (pend_rx),
  .pend_ovr_i   (pend_ovr),
  .pend_txerr_i (pend_txerr)
);

// File: tb/uart_regbank_bench.sv
module uart_regbank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int A_CTRL = 0, A_RXD = 4, A_TXD = 8, A_STAT = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        tx_push, rx_pop, rx_line, irq;
  logic [7:0]  tx_data;
  logic        tx_full = 0, tx_empty = 1, rx_empty = 1;
  logic [4:0]  tx_level = '0, rx_level = '0;
  logic [7:0]  rx_data = '0;
  logic        rx_overrun = 0, rx_err = 0, cts = 0, rts = 0, busy = 0;
  logic        tx_serial = 0, rx_serial = 0;
  logic [1:0]  word_len;
  logic [2:0]  parity;
  logic        two_stop, flow_en, tx_run, rx_run, rx_dma, tx_dma, loopback;

  int total = 0, bad = 0;
  bit done = 0;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_regbank u_uart_regbank (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tx_push_o(tx_push), .tx_data_o(tx_data),
    .tx_full_i(tx_full), .tx_empty_i(tx_empty), .tx_level_i(tx_level),
    .rx_pop_o(rx_pop), .rx_data_i(rx_data), .rx_empty_i(rx_empty), .rx_level_i(rx_level),
    .rx_overrun_i(rx_overrun), .rx_err_i(rx_err), .cts_i(cts), .rts_i(rts), .busy_i(busy),
    .tx_serial_i(tx_serial), .rx_serial_i(rx_serial), .rx_line_o(rx_line),
    .word_len_o(word_len), .two_stop_o(two_stop), .parity_o(parity), .flow_en_o(flow_en),
    .tx_run_o(tx_run), .rx_run_o(rx_run), .rx_dma_en_o(rx_dma), .tx_dma_en_o(tx_dma),
    .loopback_o(loopback), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; addr = 4'(a); wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wr_tx(input logic [7:0] d, input logic exp_push, input string tag);
    @(negedge clk);
    wr_en = 1; addr = 4'(A_TXD); wdata = {24'hFFFF_FF, d};
    #1;
    chk({tag, " push"}, 32'(tx_push), 32'(exp_push));
    if (exp_push) chk({tag, " data"}, 32'(tx_data), 32'(d));
    @(negedge clk);
    wr_en = 0;
  endtask

  // driver: issue a read and queue the expected word
  task automatic rd(input int a, input logic [31:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    rd_en = 1; addr = 4'(a);
    it.exp = exp; it.tag = tag;
    exp_q.push_back(it);
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic rd_rx(input logic [31:0] exp, input logic exp_pop, input string tag);
    item_t it;
    @(negedge clk);
    rd_en = 1; addr = 4'(A_RXD);
    it.exp = exp; it.tag = tag;
    exp_q.push_back(it);
    #1;
    chk({tag, " pop"}, 32'(rx_pop), 32'(exp_pop));
    @(negedge clk);
    rd_en = 0;
  endtask

  // monitor: compare registered read data
  initial begin
    forever begin
      @(posedge clk);
      if (rd_en) begin
        item_t it;
        @(negedge clk);
        it = exp_q.pop_front();
        chk(it.tag, rdata, it.exp);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=%h exp=%h", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset
    chk("R1 irq", 32'(irq), 0);
    rd(A_CTRL, 32'h0, "R1 ctrl");
    rd(A_STAT, 32'h420, "R1 stat");

    // R2 field map
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, 32'h001F_D077, "R2 readback");
    chk("R2 word_len", 32'(word_len), 3);
    chk("R2 parity", 32'(parity), 7);
    chk("R2 misc", 32'({two_stop, flow_en, rx_dma, tx_dma, loopback, tx_run}), 32'h3F);

    // R3 loopback on
    tx_serial = 0; rx_serial = 1; #1;
    chk("R3 loop0", 32'(rx_line), 0);
    tx_serial = 1; rx_serial = 0; #1;
    chk("R3 loop1", 32'(rx_line), 1);

    // R4 disable keeps config
    wr(A_CTRL, 32'h001F_5077);
    chk("R4 run", 32'({tx_run, rx_run}), 0);
    chk("R4 cfg", 32'({word_len, loopback}), 32'h7);
    rd(A_CTRL, 32'h001F_5077, "R4 readback");

    wr(A_CTRL, 32'h0000_8003);
    rx_serial = 0; tx_serial = 1; #1;
    chk("R3 direct0", 32'(rx_line), 0);
    rx_serial = 1; tx_serial = 0; #1;
    chk("R3 direct1", 32'(rx_line), 1);

    wr(A_STAT, 32'h1F);
    rd(A_STAT, 32'h420, "R7 clear all");
    chk("R10 irq idle", 32'(irq), 0);

    // R5 / R6
    wr_tx(8'hA5, 1, "R5");
    tx_full = 1;
    wr_tx(8'h5A, 0, "R6");
    rd(A_STAT, 32'h468, "R6 txerr set");
    wr(A_STAT, 32'h8);
    rd(A_STAT, 32'h460, "R7 txerr clear");
    tx_full = 0;

    // R8 / R10 RX path
    rx_empty = 0; rx_data = 8'h3C; rx_level = 5'd3;
    repeat (2) @(negedge clk);
    chk("R10 irq masked", 32'(irq), 0);
    rd(A_STAT, 32'h1C01, "R10 rx pend");
    wr(A_CTRL, 32'h0004_8003);
    chk("R10 irq on", 32'(irq), 1);
    rd_rx(32'h3C, 1, "R8 pop");
    rx_empty = 1; rx_level = 0;
    wr(A_STAT, 32'h1);
    chk("R10 irq cleared", 32'(irq), 0);
    rd(A_STAT, 32'h420, "R10 stat cleared");
    rd_rx(32'h0, 0, "R8 empty");

    // R9 level select
    tx_empty = 0; tx_level = 5'd5; rx_level = 5'd2;
    wr(A_CTRL, 32'h0000_C003);
    rd(A_STAT, 32'h2820, "R9 tx level");
    wr(A_CTRL, 32'h0000_8003);
    rd(A_STAT, 32'h1020, "R9 rx level");

    // R11 TX pending at half-depth boundary
    rx_level = 0; tx_level = 5'd7;
    wr(A_CTRL, 32'h0008_8003);
    @(negedge clk);
    rd(A_STAT, 32'h22, "R11 below half");
    chk("R11 irq", 32'(irq), 1);
    tx_level = 5'd8;
    wr(A_STAT, 32'h2);
    rd(A_STAT, 32'h20, "R11 at half");
    chk("R11 irq low", 32'(irq), 0);
    tx_level = 5'd7;
    repeat (2) @(negedge clk);
    chk("R11 rearm", 32'(irq), 1);
    tx_level = 5'd8;
    wr(A_STAT, 32'h2);

    // R12 sticky errors, no interrupt
    @(negedge clk);
    rx_overrun = 1; rx_err = 1;
    @(negedge clk);
    rx_overrun = 0; rx_err = 0;
    repeat (2) @(negedge clk);
    rd(A_STAT, 32'h34, "R12 sticky");
    chk("R12 no irq", 32'(irq), 0);
    wr(A_STAT, 32'h14);
    rd(A_STAT, 32'h20, "R12 cleared");

    // R13 line mirrors
    cts = 1; rts = 1; busy = 1; tx_full = 1;
    rd(A_STAT, 32'h201E0, "R13 lines");

    repeat (3) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule